// File: doc/BRIEF.md
# SPI Flash Command Master

This block runs complete serial-flash style transactions as an SPI master in clock mode 0. A host presents an 8-bit command code, an optional 24-bit address, a read/write select, a byte count and up to eight bytes of write data, then pulses a start input. The block pulls the active-low chip select down, shifts the frame out on MOSI, collects MISO bits during the data phase of a read, and releases chip select only on a byte boundary.

The serial clock is derived from the system clock by a programmable divider: each SCLK half period lasts `clk_div_i + 1` system cycles. The command code and address go out most significant bit first. Data bytes travel lowest byte first, with every byte still sent and received most significant bit first. Read data comes back as a 64-bit word whose low byte is the first byte received. A one-cycle done pulse marks the end of each frame, and a minimum chip-select-high interval separates back-to-back frames.

Top module: `spi_cmd_master`

## Requirements
- R1: SCLK is low whenever chip select is high (mode 0 idle), and MOSI does not change while SCLK is high.
- R2: A frame has exactly 8 + 24·addr_en_i + 8·n SCLK rising edges, where n is the effective byte count. Chip select rises only after a whole number of bytes, with SCLK low.
- R3: A start pulse while idle is taken on that clock edge: chip select falls and busy rises at that edge. A start pulse while busy is ignored, starts no further frame and leaves the frame in progress unchanged.
- R4: The 8-bit command code is shifted first, bit 7 first. If addr_en_i is 1, the 24-bit address follows with bit 23 first and bit 0 last. If addr_en_i is 0, the address phase is skipped.
- R5: Every SCLK half period lasts clk_div_i + 1 system cycles. The first rising edge comes clk_div_i + 1 cycles after chip select falls, and chip select rises on the cycle of the last falling edge.
- R6: On a write (write_i = 1), the data phase sends wdata_i[7:0] first, then wdata_i[15:8], and so on. Each byte is sent bit 7 first.
- R7: On a read (write_i = 0), MOSI is low during the data phase. MISO is sampled on each SCLK rising edge, and received byte k lands in rdata_o[8k+7:8k], with its first bit in bit 8k+7. rdata_o is cleared when a frame starts, so unused bytes read as zero and a write leaves rdata_o at zero.
- R8: nbytes_i = 0 is treated as one byte, and any value above 8 is treated as eight bytes.
- R9: done_o is a single-cycle pulse that is high in exactly the cycle in which chip select returns high. rdata_o is final in that cycle.
- R10: busy_o stays high after chip select rises, so chip select stays high for at least 2·(clk_div_i + 1) cycles before the next frame can begin.
- R11: During and after reset, chip select is high, SCLK and MOSI are low, and busy_o, done_o and rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only while idle |
| opcode_i | input | 8 | Command code |
| addr_en_i | input | 1 | 1 = send the 24-bit address phase |
| addr_i | input | 24 | Flash address |
| write_i | input | 1 | 1 = write data phase, 0 = read data phase |
| nbytes_i | input | 4 | Data byte count (1 to 8, clamped) |
| wdata_i | input | 64 | Write data, byte 0 in bits 7:0 |
| clk_div_i | input | 8 | SCLK half period minus one, in system cycles |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| done_o | output | 1 | One-cycle pulse at chip select release |
| rdata_o | output | 64 | Read data, first byte in bits 7:0 |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
A wrong bit counter or header length shows up at the first bad position. A MOSI bit that differs from the expected stream is flagged on the very SCLK rising edge that carries it, and a frame that is too long or too short is flagged when chip select rises. A wrong divider count is visible within one half period. A wrong capture index appears only in rdata_o, and that output is compared in the cycle of the done pulse. A lost or extra done pulse, or a start that should have been ignored but was taken, is caught within a cycle of chip select moving.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int OP_W   = 8;
  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_GAP
  } spi_st_e;
endpackage

// File: rtl/spi_tick_gen.sv
module spi_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_frame_pack.sv
module spi_frame_pack
  import spi_cmd_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int NB_W      = 4,
  parameter int CNT_W     = 7
) (
  input  logic [OP_W-1:0]                      opcode_i,
  input  logic                                 addr_en_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic                                 write_i,
  input  logic [NB_W-1:0]                      nbytes_i,
  input  logic [8*MAX_BYTES-1:0]               wdata_i,
  output logic [OP_W+ADDR_W+8*MAX_BYTES-1:0]   frame_o,
  output logic [CNT_W-1:0]                     nbits_o,
  output logic [CNT_W-1:0]                     hdr_o
);
  localparam int DATA_W = 8 * MAX_BYTES;

  logic [DATA_W-1:0] dstream;

  // byte 0 leads the data stream; read frames shift zeros
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_byte
    assign dstream[DATA_W-1-8*k -: 8] = write_i ? wdata_i[8*k +: 8] : 8'h00;
  end

  assign frame_o = addr_en_i ? {opcode_i, addr_i, dstream}
                             : {opcode_i, dstream, {ADDR_W{1'b0}}};
  assign hdr_o   = addr_en_i ? CNT_W'(OP_W + ADDR_W) : CNT_W'(OP_W);
  assign nbits_o = hdr_o + (CNT_W'(nbytes_i) << 3);
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int MAX_BYTES = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   en_i,
  input  logic                   bit_i,
  output logic [8*MAX_BYTES-1:0] rdata_o
);
  localparam int DATA_W = 8 * MAX_BYTES;
  localparam int DIDX_W = $clog2(DATA_W);

  logic [DIDX_W-1:0] cnt_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rdata_q <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      rdata_q <= '0;
    end else if (en_i) begin
      // flip the bit-in-byte index: first bit of a byte is its MSB
      rdata_q[cnt_q ^ DIDX_W'(7)] <= bit_i;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master
  import spi_cmd_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int MAX_BYTES = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic [OP_W-1:0]                opcode_i,
  input  logic                           addr_en_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           write_i,
  input  logic [$clog2(MAX_BYTES+1)-1:0] nbytes_i,
  input  logic [8*MAX_BYTES-1:0]         wdata_i,
  input  logic [DIV_W-1:0]               clk_div_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic [8*MAX_BYTES-1:0]         rdata_o,
  output logic                           sclk_o,
  output logic                           cs_no,
  output logic                           mosi_o,
  input  logic                           miso_i
);
  localparam int DATA_W  = 8 * MAX_BYTES;
  localparam int FRAME_W = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int NB_W    = $clog2(MAX_BYTES + 1);

  spi_st_e            st_q;
  logic               cs_n_q, sclk_q, done_q, rd_q, gap_q;
  logic [FRAME_W-1:0] tx_q;
  logic [CNT_W-1:0]   bit_q, nbits_q, hdr_q;

  logic [NB_W-1:0]    nb_eff;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits, hdr;
  logic               tick, accept, cap_en;

  always_comb begin
    if (nbytes_i == '0)                     nb_eff = NB_W'(1);
    else if (nbytes_i > NB_W'(MAX_BYTES))   nb_eff = NB_W'(MAX_BYTES);
    else                                    nb_eff = nbytes_i;
  end

  spi_frame_pack #(
    .MAX_BYTES (MAX_BYTES),
    .NB_W      (NB_W),
    .CNT_W     (CNT_W)
  ) u_pack (
    .opcode_i  (opcode_i),
    .addr_en_i (addr_en_i),
    .addr_i    (addr_i),
    .write_i   (write_i),
    .nbytes_i  (nb_eff),
    .wdata_i   (wdata_i),
    .frame_o   (frame),
    .nbits_o   (nbits),
    .hdr_o     (hdr)
  );

  spi_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (st_q != ST_IDLE),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  assign accept = (st_q == ST_IDLE) && start_i;
  assign cap_en = (st_q == ST_SHIFT) && tick && !sclk_q && rd_q && (bit_q >= hdr_q);

  spi_rx_capture #(.MAX_BYTES(MAX_BYTES)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .en_i    (cap_en),
    .bit_i   (miso_i),
    .rdata_o (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      done_q  <= 1'b0;
      rd_q    <= 1'b0;
      gap_q   <= 1'b0;
      tx_q    <= '0;
      bit_q   <= '0;
      nbits_q <= '0;
      hdr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_SHIFT;
          cs_n_q  <= 1'b0;
          sclk_q  <= 1'b0;
          tx_q    <= frame;
          bit_q   <= '0;
          nbits_q <= nbits;
          hdr_q   <= hdr;
          rd_q    <= !write_i;
        end
        ST_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (bit_q == nbits_q - 1'b1) begin
              // release only after the falling edge closing the last byte
              cs_n_q <= 1'b1;
              done_q <= 1'b1;
              gap_q  <= 1'b0;
              st_q   <= ST_GAP;
            end else begin
              bit_q <= bit_q + 1'b1;
              tx_q  <= {tx_q[FRAME_W-2:0], 1'b0};
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gap_q) st_q <= ST_IDLE;
          else       gap_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign cs_no  = cs_n_q;
  assign mosi_o = tx_q[FRAME_W-1] & ~cs_n_q;
endmodule

// File: rtl/spi_cmd_master_chk.sv
module spi_cmd_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o
);
  logic       sclk_d;
  logic [2:0] rise_mod;
  logic [1:0] hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      rise_mod <= '0;
      hi_cnt   <= 2'd3;
    end else begin
      sclk_d <= sclk_o;
      if (sclk_o && !sclk_d) rise_mod <= rise_mod + 1'b1;
      if (!cs_no)              hi_cnt <= '0;
      else if (hi_cnt != 2'd3) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o); // R1
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o)); // R1
  AST_BYTE_ALIGNED_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_mod == 3'd0 && !sclk_o)); // R2
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !cs_no)); // R3
  AST_DONE_AT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $rose(cs_no)); // R9
  AST_RELEASE_HAS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R10
  AST_GAP_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= 2'd2)); // R10
endmodule

bind spi_cmd_master spi_cmd_master_chk u_chk (.*);

// File: tb/spi_cmd_master_bench.sv
`timescale 1ns/1ps
module spi_cmd_master_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [7:0]  opcode_i = '0, clk_div_i = '0;
  logic        addr_en_i = 1'b0, write_i = 1'b0, miso_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [3:0]  nbytes_i = '0;
  logic [63:0] wdata_i = '0;
  logic        busy_o, done_o, sclk_o, cs_no, mosi_o;
  logic [63:0] rdata_o;

  spi_cmd_master u_spi_cmd_master (.*);

  always #2 clk_i = ~clk_i;

  int n_chk = 0, n_bad = 0, cyc = 0, n_txn = 0;
  bit exp_q[$];
  int hdr_m = 8, div_m = 0, tot_m = 0, gap_req = 0, gap = 1000;
  int since = 0, rises = 0, falls = 0;
  bit rd_m = 1'b0, active = 1'b0;
  logic [63:0] resp_m = '0, exp_rd_m = '0;
  string tag_m = "";
  logic p_sclk = 1'b0, p_cs = 1'b1, p_mosi = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  function automatic logic miso_bit(input int k);
    int j;
    if (!rd_m || k < hdr_m) return 1'b1;
    j = k - hdr_m;
    return resp_m[(j / 8) * 8 + 7 - (j % 8)];
  endfunction

  function automatic string phase_tag(input int k);
    if (k < 8)     return "R4 opcode";
    if (k < hdr_m) return "R4 address";
    return rd_m ? "R7 read mosi low" : "R6 write data";
  endfunction

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      summary();
    end
  end

  // reference model of the bus, evaluated every cycle
  always @(negedge clk_i) if (active) begin
    since++;
    chk(!(cs_no && sclk_o), "R1 sclk idle low", sclk_o, 0);
    chk(done_o == (cs_no && !p_cs), "R9 done with release", done_o, cs_no && !p_cs);
    if (done_o) chk(busy_o, "R10 busy at release", busy_o, 1);
    if (sclk_o && p_sclk) chk(mosi_o == p_mosi, "R1 mosi hold", mosi_o, p_mosi);
    if (p_cs && !cs_no) begin
      chk(gap >= gap_req, "R10 cs high gap", gap, gap_req);
      falls++; rises = 0; since = 0;
      miso_i = miso_bit(0);
    end
    if (!p_sclk && sclk_o) begin
      chk(since == div_m + 1, "R5 half period", since, div_m + 1);
      if (exp_q.size() == 0) chk(1'b0, "R2 extra bit", rises, tot_m);
      else begin
        bit eb;
        eb = exp_q.pop_front();
        chk(mosi_o == eb, phase_tag(rises), mosi_o, eb);
      end
      rises++; since = 0;
    end
    if (p_sclk && !sclk_o) begin
      chk(since == div_m + 1, "R5 half period", since, div_m + 1);
      since = 0;
      if (!cs_no) miso_i = miso_bit(rises);
    end
    if (!p_cs && cs_no) begin
      chk(rises == tot_m, {"R2 frame length ", tag_m}, rises, tot_m);
      chk(rdata_o == exp_rd_m, {"R7 rdata ", tag_m}, rdata_o, exp_rd_m);
      gap = 0; gap_req = 2 * (div_m + 1);
    end
    if (cs_no) gap++;
    p_sclk = sclk_o; p_cs = cs_no; p_mosi = mosi_o;
  end

  task automatic run_txn(input logic [7:0] op, input bit aen, input logic [23:0] ad, input bit wr,
                         input int n, input logic [63:0] wd, input logic [63:0] resp,
                         input int div, input string tag, input int poke);
    int neff;
    while (busy_o) @(negedge clk_i);
    neff = (n == 0) ? 1 : ((n > 8) ? 8 : n);
    exp_q.delete();
    for (int i = 7; i >= 0; i--) exp_q.push_back(op[i]);
    if (aen) for (int i = 23; i >= 0; i--) exp_q.push_back(ad[i]);
    for (int b = 0; b < neff; b++)
      for (int i = 7; i >= 0; i--) exp_q.push_back(wr ? wd[8*b+i] : 1'b0);
    hdr_m = aen ? 32 : 8;
    rd_m = !wr; resp_m = resp; div_m = div; tag_m = tag;
    tot_m = hdr_m + 8 * neff;
    exp_rd_m = '0;
    if (!wr) for (int b = 0; b < neff; b++) exp_rd_m[8*b +: 8] = resp[8*b +: 8];
    opcode_i = op; addr_en_i = aen; addr_i = ad; write_i = wr;
    nbytes_i = 4'(n); wdata_i = wd; clk_div_i = 8'(div);
    start_i = 1'b1;
    n_txn++;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke > 0) begin
      repeat (poke) @(negedge clk_i);
      opcode_i = 8'hFF; addr_en_i = 1'b0; write_i = 1'b1; nbytes_i = 4'd1;
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(cs_no && !sclk_o && !mosi_o, "R11 pins in reset", {cs_no, sclk_o, mosi_o}, 3'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(cs_no === 1'b1, "R11 cs high", cs_no, 1);
    chk(!busy_o && !done_o, "R11 busy done low", {busy_o, done_o}, 0);
    chk(rdata_o == '0, "R11 rdata zero", rdata_o, 0);
    active = 1'b1;

    run_txn(8'h03, 1, 24'hA53C81, 0, 4, '0, 64'h0123_4567_89AB_CDEF, 1, "", 0);
    run_txn(8'h02, 1, 24'h123456, 1, 8, 64'h8877_6655_4433_2211, '1, 2, "", 0);
    run_txn(8'h9F, 0, '0, 0, 2, '0, 64'h0000_0000_0000_C2E5, 0, "", 0);
    run_txn(8'h06, 0, '0, 1, 0, 64'h0000_0000_0000_005A, '1, 3, "R8 zero count", 0);
    run_txn(8'h02, 1, 24'hFFFFFF, 1, 12, 64'hF0E1_D2C3_B4A5_9687, '1, 0, "R8 over count", 0);
    run_txn(8'h0B, 1, 24'h800001, 0, 8, '0, 64'hDEAD_BEEF_5A5A_A55A, 3, "R3 start while busy", 20);
    run_txn(8'h05, 0, '0, 0, 1, '0, 64'h0000_0000_0000_0081, 0, "", 0);
    run_txn(8'h02, 1, 24'h00F00F, 1, 3, 64'h0000_0000_0033_2211, '1, 1, "write leaves rdata zero", 0);

    while (busy_o) @(negedge clk_i);
    repeat (10) @(negedge clk_i);
    chk(cs_no === 1'b1, "R3 no extra frame, cs high", cs_no, 1);
    chk(falls == n_txn, "R3 frame count", falls, n_txn);
    chk(exp_q.size() == 0, "R2 all bits sent", exp_q.size(), 0);
    summary();
  end
endmodule